// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block lives in the decode stage of a five-stage integer pipeline. Decode hands it the fields it has already decoded: the two source register numbers and a flag for each saying whether the instruction reads it. A third flag marks an rt that is read only as store data. Decode also supplies the load flag, destination and control bits that the instruction would carry into execute. The block owns the decode-to-execute control register. That register tells it whether the instruction now in execute is a load and which register the load writes.

When the instruction in decode reads a register that a load in execute is about to produce, forwarding cannot supply the value in time. In that case the block stalls for one cycle. It drops the PC write enable and holds the fetch/decode register so that it recirculates its contents. It also loads an all-zero no-op into the execute control register. On the next cycle the load has moved to the memory stage, the bubble sits in execute, and the held instruction issues with its operand forwarded.

A store whose only dependence on the load is its data operand does not stall, because that value is forwarded into the memory input. Register 0 never creates a dependence.

Top module: `loaduse_stall_ctrl`

## Requirements
- R1: When `dec_valid` is 1, `ex_load_q` is 1, `ex_dst_q` is nonzero, `dec_use_rs` is 1 and `dec_rs` equals `ex_dst_q`, the block stalls in the same cycle: `pc_we`=0, `ifid_hold`=1, `idex_bubble`=1.
- R2: When `dec_valid` is 1, `ex_load_q` is 1, `ex_dst_q` is nonzero, `dec_use_rt` is 1, `dec_rt_store_only` is 0 and `dec_rt` equals `ex_dst_q`, the block stalls as in R1.
- R3: An rt match with `dec_rt_store_only`=1 (rt read only as store data) causes no stall.
- R4: A load whose destination is register 0 never causes a stall.
- R5: When `ex_load_q` is 0, no stall occurs, whatever the source fields are.
- R6: At a clock edge where `idex_bubble` is 1 or `dec_valid` is 0, the execute register becomes all zero (`ex_load_q`=0, `ex_dst_q`=0, `ex_ctrl_q`=0). Otherwise it captures `dec_is_load`, `dec_dst` and `dec_ctrl`.
- R7: A stall lasts exactly one cycle. In the cycle after a stall, `idex_bubble` is 0 and the held instruction issues.
- R8: After reset, the execute register is all zero and the outputs show no stall (`pc_we`=1, `ifid_hold`=0, `idex_bubble`=0).
- R9: When `dec_valid` is 0, no stall occurs.
- R10: With no stall, `pc_we`=1, `ifid_hold`=0 and `idex_bubble`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rs | input | REG_W | First source register number |
| dec_rt | input | REG_W | Second source register number |
| dec_use_rs | input | 1 | Instruction reads rs |
| dec_use_rt | input | 1 | Instruction reads rt |
| dec_rt_store_only | input | 1 | rt is read only as store data |
| dec_is_load | input | 1 | Decoded instruction is a load |
| dec_dst | input | REG_W | Destination of the decoded instruction |
| dec_ctrl | input | CTRL_W | Other execute-stage control bits |
| pc_we | output | 1 | PC write enable |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| idex_bubble | output | 1 | Insert a no-op into execute |
| ex_load_q | output | 1 | Execute stage holds a load |
| ex_dst_q | output | REG_W | Execute stage destination |
| ex_ctrl_q | output | CTRL_W | Execute stage control bits |

## Verification
The bench builds the block with REG_W=3 and CTRL_W=4. With only eight register numbers, random source fields often match the load destination, so rs hits, rt hits, store-data-only matches and register-0 loads all occur many times. Back-to-back dependent loads are also frequent. Together these exercise the one-cycle stall followed by issue, as well as the execute-register clear, within a few thousand cycles.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int NSRC = 2;

    typedef enum logic [0:0] {
        SRC_RS = 1'b0,
        SRC_RT = 1'b1
    } src_idx_e;

    typedef struct packed {
        logic             stall;
        logic [NSRC-1:0]  hit;
    } hz_res_t;

endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
    parameter int REG_W = 5
) (
    input  logic             src_used,
    input  logic [REG_W-1:0] src_reg,
    input  logic             ex_load,
    input  logic [REG_W-1:0] ex_dst,
    output logic             hit
);

    logic dst_nonzero;

    always_comb begin
        dst_nonzero = (ex_dst != '0);
        hit         = src_used && ex_load && dst_nonzero && (src_reg == ex_dst);
    end

endmodule

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect
    import lu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             dec_use_rs,
    input  logic             dec_use_rt,
    input  logic             dec_rt_store_only,
    input  logic             ex_load,
    input  logic [REG_W-1:0] ex_dst,
    output hz_res_t          res
);

    logic [NSRC-1:0][REG_W-1:0] src_regs;
    logic [NSRC-1:0]            src_used;
    logic [NSRC-1:0]            src_hit;

    always_comb begin
        src_regs[SRC_RS] = dec_rs;
        src_regs[SRC_RT] = dec_rt;
        src_used[SRC_RS] = dec_valid && dec_use_rs;
        // store data is forwarded into the memory input, so it never stalls
        src_used[SRC_RT] = dec_valid && dec_use_rt && !dec_rt_store_only;
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        lu_src_match #(
            .REG_W (REG_W)
        ) i_match (
            .src_used (src_used[gi]),
            .src_reg  (src_regs[gi]),
            .ex_load  (ex_load),
            .ex_dst   (ex_dst),
            .hit      (src_hit[gi])
        );
    end

    always_comb begin
        res.hit   = src_hit;
        res.stall = |src_hit;
    end

    p_zero_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !res.stall);

    p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !res.stall);

    p_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !res.stall);

    p_store_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_rt_store_only && !(dec_use_rs && dec_rs == ex_dst)) |-> !res.stall);

endmodule

// File: rtl/lu_idex_reg.sv
module lu_idex_reg #(
    parameter int REG_W  = 5,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bubble,
    input  logic              dec_valid,
    input  logic              dec_is_load,
    input  logic [REG_W-1:0]  dec_dst,
    input  logic [CTRL_W-1:0] dec_ctrl,
    output logic              ex_load_q,
    output logic [REG_W-1:0]  ex_dst_q,
    output logic [CTRL_W-1:0] ex_ctrl_q
);

    typedef struct packed {
        logic              load;
        logic [REG_W-1:0]  dst;
        logic [CTRL_W-1:0] ctrl;
    } idex_t;

    idex_t st_d, st_q;

    always_comb begin
        if (bubble || !dec_valid) begin
            st_d = '0;
        end else begin
            st_d.load = dec_is_load;
            st_d.dst  = dec_dst;
            st_d.ctrl = dec_ctrl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_load_q = st_q.load;
    assign ex_dst_q  = st_q.dst;
    assign ex_ctrl_q = st_q.ctrl;

    p_bubble_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ex_ctrl_q == '0 && !ex_load_q && ex_dst_q == '0));

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && dec_valid) |=>
            (ex_ctrl_q == $past(dec_ctrl) && ex_dst_q == $past(dec_dst)
             && ex_load_q == $past(dec_is_load)));

endmodule

// File: rtl/loaduse_stall_ctrl.sv
module loaduse_stall_ctrl
    import lu_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [REG_W-1:0]  dec_rs,
    input  logic [REG_W-1:0]  dec_rt,
    input  logic              dec_use_rs,
    input  logic              dec_use_rt,
    input  logic              dec_rt_store_only,
    input  logic              dec_is_load,
    input  logic [REG_W-1:0]  dec_dst,
    input  logic [CTRL_W-1:0] dec_ctrl,
    output logic              pc_we,
    output logic              ifid_hold,
    output logic              idex_bubble,
    output logic              ex_load_q,
    output logic [REG_W-1:0]  ex_dst_q,
    output logic [CTRL_W-1:0] ex_ctrl_q
);

    hz_res_t hz;

    lu_hazard_detect #(
        .REG_W (REG_W)
    ) i_detect (
        .clk               (clk),
        .rst_n             (rst_n),
        .dec_valid         (dec_valid),
        .dec_rs            (dec_rs),
        .dec_rt            (dec_rt),
        .dec_use_rs        (dec_use_rs),
        .dec_use_rt        (dec_use_rt),
        .dec_rt_store_only (dec_rt_store_only),
        .ex_load           (ex_load_q),
        .ex_dst            (ex_dst_q),
        .res               (hz)
    );

    always_comb begin
        pc_we       = !hz.stall;
        ifid_hold   = hz.stall;
        idex_bubble = hz.stall;
    end

    lu_idex_reg #(
        .REG_W  (REG_W),
        .CTRL_W (CTRL_W)
    ) i_idex (
        .clk         (clk),
        .rst_n       (rst_n),
        .bubble      (hz.stall),
        .dec_valid   (dec_valid),
        .dec_is_load (dec_is_load),
        .dec_dst     (dec_dst),
        .dec_ctrl    (dec_ctrl),
        .ex_load_q   (ex_load_q),
        .ex_dst_q    (ex_dst_q),
        .ex_ctrl_q   (ex_ctrl_q)
    );

    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |=> !idex_bubble);

    p_rs_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ex_load_q && ex_dst_q != '0 && dec_use_rs && dec_rs == ex_dst_q)
            |-> (!pc_we && ifid_hold));

    p_rt_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && ex_load_q && ex_dst_q != '0 && dec_use_rt && !dec_rt_store_only
         && dec_rt == ex_dst_q) |-> (!pc_we && ifid_hold));

endmodule

// File: tb/test_loaduse_stall_ctrl.sv
module test_loaduse_stall_ctrl;

    localparam int RW = 3;
    localparam int CW = 4;
    localparam time HALF = 2ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid, dec_use_rs, dec_use_rt, dec_rt_store_only, dec_is_load;
    logic [RW-1:0] dec_rs, dec_rt, dec_dst;
    logic [CW-1:0] dec_ctrl;
    logic          pc_we, ifid_hold, idex_bubble, ex_load_q;
    logic [RW-1:0] ex_dst_q;
    logic [CW-1:0] ex_ctrl_q;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  seed_dummy;

    logic          m_load;
    logic [RW-1:0] m_dst;
    logic [CW-1:0] m_ctrl;
    logic          m_prev_stall;

    always #HALF clk = ~clk;

    loaduse_stall_ctrl #(.REG_W(RW), .CTRL_W(CW)) i_loaduse_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_rs(dec_rs), .dec_rt(dec_rt),
        .dec_use_rs(dec_use_rs), .dec_use_rt(dec_use_rt), .dec_rt_store_only(dec_rt_store_only),
        .dec_is_load(dec_is_load), .dec_dst(dec_dst), .dec_ctrl(dec_ctrl),
        .pc_we(pc_we), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ex_load_q(ex_load_q), .ex_dst_q(ex_dst_q), .ex_ctrl_q(ex_ctrl_q));

    function automatic logic exp_stall();
        logic rs_hit, rt_hit;
        rs_hit = dec_use_rs && (dec_rs == m_dst);
        rt_hit = dec_use_rt && !dec_rt_store_only && (dec_rt == m_dst);
        return dec_valid && m_load && (m_dst != '0) && (rs_hit || rt_hit);
    endfunction

    function automatic string tag_for(logic st);
        if (st) return (dec_use_rs && dec_rs == m_dst) ? "R1" : "R2";
        if (!dec_valid) return "R9";
        if (!m_load) return "R5";
        if (m_dst == '0) return "R4";
        if (dec_rt_store_only && dec_rt == m_dst) return "R3";
        return "R10";
    endfunction

    task automatic chk(string tag, int act, int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic drive(logic v, logic [RW-1:0] rs, logic [RW-1:0] rt, logic urs, logic urt,
                         logic so, logic ld, logic [RW-1:0] dst, logic [CW-1:0] ctl);
        logic st;
        dec_valid = v; dec_rs = rs; dec_rt = rt; dec_use_rs = urs; dec_use_rt = urt;
        dec_rt_store_only = so; dec_is_load = ld; dec_dst = dst; dec_ctrl = ctl;
        #1;
        // R6: registered state against model
        chk("R6 load", int'(ex_load_q), int'(m_load));
        chk("R6 dst",  int'(ex_dst_q),  int'(m_dst));
        chk("R6 ctrl", int'(ex_ctrl_q), int'(m_ctrl));
        st = exp_stall();
        chk({tag_for(st), " pc_we"},  int'(pc_we),       int'(!st));
        chk({tag_for(st), " hold"},   int'(ifid_hold),   int'(st));
        chk({tag_for(st), " bubble"}, int'(idex_bubble), int'(st));
        if (m_prev_stall) chk("R7 no second stall", int'(idex_bubble), 0);
        m_prev_stall = st;
        if (st || !v) begin
            m_load = 1'b0; m_dst = '0; m_ctrl = '0;
        end else begin
            m_load = ld; m_dst = dst; m_ctrl = ctl;
        end
        @(negedge clk);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        seed_dummy = $urandom(32'h5eed1234);
        m_load = 1'b0; m_dst = '0; m_ctrl = '0; m_prev_stall = 1'b0;
        dec_valid = 0; dec_rs = 0; dec_rt = 0; dec_use_rs = 0; dec_use_rt = 0;
        dec_rt_store_only = 0; dec_is_load = 0; dec_dst = 0; dec_ctrl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state
        chk("R8 pc_we", int'(pc_we), 1);
        chk("R8 hold", int'(ifid_hold), 0);
        chk("R8 bubble", int'(idex_bubble), 0);
        chk("R8 ex", int'({ex_load_q, ex_dst_q, ex_ctrl_q}), 0);
        @(negedge clk);

        // R1: load r3, then use rs=r3; held instr reissues next cycle (R7)
        drive(1, 0, 0, 0, 0, 0, 1, 3, 4'h9);
        drive(1, 3, 5, 1, 1, 0, 0, 6, 4'h2);
        drive(1, 3, 5, 1, 1, 0, 0, 6, 4'h2);
        // R2: rt hit
        drive(1, 0, 0, 0, 0, 0, 1, 5, 4'h1);
        drive(1, 1, 5, 1, 1, 0, 0, 2, 4'h3);
        drive(1, 1, 5, 1, 1, 0, 0, 2, 4'h3);
        // R3: store data only
        drive(1, 0, 0, 0, 0, 0, 1, 4, 4'h1);
        drive(1, 2, 4, 1, 1, 1, 0, 0, 4'h7);
        // R4: load to r0
        drive(1, 0, 0, 0, 0, 0, 1, 0, 4'h1);
        drive(1, 0, 0, 1, 1, 0, 0, 1, 4'h5);
        // R5: non-load ahead
        drive(1, 0, 0, 0, 0, 0, 0, 6, 4'hf);
        drive(1, 6, 6, 1, 1, 0, 0, 1, 4'h5);
        // R9: invalid decode behind a load
        drive(1, 0, 0, 0, 0, 0, 1, 2, 4'h1);
        drive(0, 2, 2, 1, 1, 0, 1, 2, 4'h6);
        drive(1, 2, 2, 1, 1, 0, 0, 1, 4'h6);
        // R7: dependent loads back to back
        drive(1, 0, 0, 0, 0, 0, 1, 1, 4'h8);
        drive(1, 1, 0, 1, 0, 0, 1, 2, 4'h8);
        drive(1, 1, 0, 1, 0, 0, 1, 2, 4'h8);
        drive(1, 2, 0, 1, 0, 0, 0, 3, 4'h4);
        drive(1, 2, 0, 1, 0, 0, 0, 3, 4'h4);

        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 8) != 0, RW'($urandom), RW'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), RW'($urandom), CW'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule